// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit with Nibble-Carry Flags

This block is the arithmetic core of a small eight-bit processor datapath. It is purely combinational. The caller presents an accumulator value, a second operand, the current packed flag byte, an operation code and a bit index. Within the same cycle the block returns a result byte, the updated flag byte and a write-enable. The write-enable tells the surrounding register file whether the result should be stored.

Four flags are tracked: zero (Z), subtract (N), half-carry (H) and carry (C).
- H is derived per operation from the carry or borrow across the low four bits, and the incoming carry is counted when the operation consumes it.
- Decimal adjust reads N to decide whether the previous operation was an addition or a subtraction, and then corrects in that direction.
- The accumulator-only rotate forms always report a clear Z. The general rotate and shift forms, which act on the operand, derive Z from their result.

Registers, instruction sequencing and memory access belong to the surrounding design. Every input and output is a plain level signal, so the block has no handshake.

Top module: `alu8_core`

## Requirements
- R1: The flag byte is packed with Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3..0 of `flags_o` are always 0, whatever arrives on bits 3..0 of `flags_i`.
- R2: ADD (code 0) and ADC (code 1) return acc+opnd, and ADC also adds the incoming C. H is set when the low-nibble sum, including the carry used, exceeds 0xF. C is set when the 9-bit sum exceeds 0xFF. N is cleared, Z is set when the result is 0, and the write-enable is 1.
- R3: SUB (code 2) and SBC (code 3) return acc−opnd, and SBC also subtracts the incoming C. H is set on a borrow out of the low nibble, including the C that was used. C is set on any borrow out of the full byte. N is set, Z follows the result, and the write-enable is 1.
- R4: CP (code 4) produces the same result and flags as SUB, but the write-enable is 0.
- R5: INC (code 5) and DEC (code 6) act on `opnd_i` and leave C at its incoming value. INC sets H when the operand's low nibble was 0xF and clears N. DEC sets H when the operand's low nibble was 0x0 and sets N. Z follows the result.
- R6: AND (code 7), OR (code 8) and XOR (code 9) combine acc with opnd. All three clear N and C and set Z from the result. AND sets H, while OR and XOR clear it.
- R7: DAA (code 10) with N clear first adds 0x06 to acc when H is set or acc[3:0] > 9. It then adds 0x60 when C is set or acc > 0x99, and in that case sets C; otherwise C is cleared. H is cleared, N is kept, and Z follows the result.
- R8: DAA with N set subtracts 0x06 from acc when H is set and 0x60 when C is set. C and N keep their incoming values, H is cleared, and Z follows the result.
- R9: The accumulator rotates act on acc: RLCA (code 11) and RRCA (code 12) rotate around the byte, while RLA (code 13) and RRA (code 14) rotate through C. The bit shifted out goes to C. Z, N and H are always cleared, even when the result is 0.
- R10: The general rotates act on opnd: RLC (code 15), RRC (code 16), RL (code 17) and RR (code 18), with the same data movement as the accumulator forms. Z is set when the result is 0, N and H are cleared, and the bit shifted out goes to C.
- R11: The shifts act on opnd. SLA (code 19) shifts left with a 0 in and bit 7 to C. SRA (code 20) shifts right keeping bit 7, with bit 0 to C. SRL (code 21) shifts right with a 0 in, with bit 0 to C. Z follows the result, and N and H are cleared.
- R12: BIT (code 22) sets Z when bit `bit_sel_i` of opnd is 0. It clears N, sets H and keeps C. The result equals opnd and the write-enable is 0.
- R13: SET (code 23) and RES (code 24) return opnd with bit `bit_sel_i` forced to 1 or 0. The flags are unchanged and the write-enable is 1.
- R14: Codes 25..31 are undefined. They return result 0 and write-enable 0, and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand; also the target of INC/DEC, the general rotates, the shifts and the bit operations |
| flags_i | input | 8 | Incoming packed flags (Z,N,H,C in bits 7..4) |
| op_i | input | 5 | Operation code |
| bit_sel_i | input | 3 | Bit index for BIT/SET/RES |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Updated packed flags, low nibble 0 |
| wr_en_o | output | 1 | Result should be written back |

## Verification
Every result, flag and write-enable depends only on the present inputs and is due in the same cycle, with zero register stages between an input change and the output. The bench changes the inputs on the falling clock edge and samples the outputs a few nanoseconds later, well before the next rising edge. Each vector is therefore judged on its own settled response. A reference function in the bench computes the expected byte, flags and write-enable for that vector, and the comparison is made on that sample.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 5;
  localparam int SELW = $clog2(DW);

  localparam int FZ = 7;
  localparam int FN = 6;
  localparam int FH = 5;
  localparam int FC = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CP   = 5'd4,  OP_INC  = 5'd5,  OP_DEC  = 5'd6,  OP_AND  = 5'd7,
    OP_OR   = 5'd8,  OP_XOR  = 5'd9,  OP_DAA  = 5'd10, OP_RLCA = 5'd11,
    OP_RRCA = 5'd12, OP_RLA  = 5'd13, OP_RRA  = 5'd14, OP_RLC  = 5'd15,
    OP_RRC  = 5'd16, OP_RL   = 5'd17, OP_RR   = 5'd18, OP_SLA  = 5'd19,
    OP_SRA  = 5'd20, OP_SRL  = 5'd21, OP_BIT  = 5'd22, OP_SET  = 5'd23,
    OP_RES  = 5'd24
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [OPW-1:0] op_i,
  input  flags_t         fin_i,
  output logic [DW-1:0]  res_o,
  output flags_t         fout_o
);
  logic          is_sub, is_step, use_cy;
  logic [DW-1:0] lhs, rhs;
  logic          cy;
  logic [NW:0]   lo_sum;
  logic [DW:0]   full_sum;

  always_comb begin
    is_sub  = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CP) || (op_i == OP_DEC);
    is_step = (op_i == OP_INC) || (op_i == OP_DEC);
    use_cy  = (op_i == OP_ADC) || (op_i == OP_SBC);
    cy      = use_cy & fin_i.c;
    lhs     = is_step ? b_i : a_i;
    rhs     = is_step ? DW'(1) : b_i;
    if (is_sub) begin
      lo_sum   = {1'b0, lhs[NW-1:0]} - {1'b0, rhs[NW-1:0]} - (NW+1)'(cy);
      full_sum = {1'b0, lhs} - {1'b0, rhs} - (DW+1)'(cy);
    end else begin
      lo_sum   = {1'b0, lhs[NW-1:0]} + {1'b0, rhs[NW-1:0]} + (NW+1)'(cy);
      full_sum = {1'b0, lhs} + {1'b0, rhs} + (DW+1)'(cy);
    end
    res_o    = full_sum[DW-1:0];
    fout_o.z = (full_sum[DW-1:0] == '0);
    fout_o.n = is_sub;
    fout_o.h = lo_sum[NW];
    fout_o.c = is_step ? fin_i.c : full_sum[DW];
  end
endmodule

// File: rtl/alu8_bitlogic.sv
module alu8_bitlogic
  import alu8_pkg::*;
(
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [OPW-1:0]  op_i,
  input  flags_t          fin_i,
  output logic [DW-1:0]   res_o,
  output flags_t          fout_o
);
  logic [DW-1:0] mask;

  for (genvar gi = 0; gi < DW; gi++) begin : g_mask
    assign mask[gi] = (sel_i == SELW'(gi));
  end

  always_comb begin
    res_o  = b_i;
    fout_o = fin_i;
    case (op_i)
      OP_AND: begin
        res_o  = a_i & b_i;
        fout_o = '{z: (res_o == '0), n: 1'b0, h: 1'b1, c: 1'b0};
      end
      OP_OR: begin
        res_o  = a_i | b_i;
        fout_o = '{z: (res_o == '0), n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_XOR: begin
        res_o  = a_i ^ b_i;
        fout_o = '{z: (res_o == '0), n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_BIT: begin
        res_o  = b_i;
        fout_o = '{z: ((b_i & mask) == '0), n: 1'b0, h: 1'b1, c: fin_i.c};
      end
      OP_SET: res_o = b_i | mask;
      OP_RES: res_o = b_i & ~mask;
      default: begin
        res_o  = b_i;
        fout_o = fin_i;
      end
    endcase
  end
endmodule

// File: rtl/alu8_rotshift.sv
module alu8_rotshift
  import alu8_pkg::*;
(
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [OPW-1:0] op_i,
  input  flags_t         fin_i,
  output logic [DW-1:0]  res_o,
  output flags_t         fout_o
);
  logic          short_form;
  logic          out_bit;
  logic [DW-1:0] src;

  always_comb begin
    short_form = (op_i == OP_RLCA) || (op_i == OP_RRCA) ||
                 (op_i == OP_RLA)  || (op_i == OP_RRA);
    src     = short_form ? a_i : b_i;
    res_o   = src;
    out_bit = fin_i.c;
    case (op_i)
      OP_RLCA, OP_RLC: begin res_o = {src[DW-2:0], src[DW-1]}; out_bit = src[DW-1]; end
      OP_RRCA, OP_RRC: begin res_o = {src[0], src[DW-1:1]};    out_bit = src[0];    end
      OP_RLA,  OP_RL:  begin res_o = {src[DW-2:0], fin_i.c};   out_bit = src[DW-1]; end
      OP_RRA,  OP_RR:  begin res_o = {fin_i.c, src[DW-1:1]};   out_bit = src[0];    end
      OP_SLA:          begin res_o = {src[DW-2:0], 1'b0};      out_bit = src[DW-1]; end
      OP_SRA:          begin res_o = {src[DW-1], src[DW-1:1]}; out_bit = src[0];    end
      OP_SRL:          begin res_o = {1'b0, src[DW-1:1]};      out_bit = src[0];    end
      default:         begin res_o = src;                      out_bit = fin_i.c;   end
    endcase
    fout_o.z = short_form ? 1'b0 : (res_o == '0);
    fout_o.n = 1'b0;
    fout_o.h = 1'b0;
    fout_o.c = out_bit;
  end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  flags_t        fin_i,
  output logic [DW-1:0] res_o,
  output flags_t        fout_o
);
  localparam logic [DW-1:0] LO_FIX = DW'(6);
  localparam logic [DW-1:0] HI_FIX = DW'(8'h60);
  localparam logic [DW-1:0] HI_LIM = DW'(8'h99);
  localparam logic [NW-1:0] LO_LIM = NW'(9);

  logic [DW-1:0] adj;
  logic          hi_need;

  always_comb begin
    adj     = '0;
    hi_need = 1'b0;
    if (fin_i.n) begin
      if (fin_i.h) adj = adj | LO_FIX;
      if (fin_i.c) adj = adj | HI_FIX;
      res_o   = a_i - adj;
      hi_need = fin_i.c;
    end else begin
      if (fin_i.h || (a_i[NW-1:0] > LO_LIM)) adj = adj | LO_FIX;
      hi_need = fin_i.c || (a_i > HI_LIM);
      if (hi_need) adj = adj | HI_FIX;
      res_o = a_i + adj;
    end
    fout_o.z = (res_o == '0);
    fout_o.n = fin_i.n;
    fout_o.h = 1'b0;
    fout_o.c = hi_need;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  input  logic [4:0] op_i,
  input  logic [2:0] bit_sel_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o,
  output logic       wr_en_o
);
  flags_t        fin;
  logic [DW-1:0] as_res, bl_res, rs_res, da_res;
  flags_t        as_f, bl_f, rs_f, da_f;
  flags_t        fsel;

  assign fin = '{z: flags_i[FZ], n: flags_i[FN], h: flags_i[FH], c: flags_i[FC]};

  alu8_addsub u_addsub (
    .a_i(acc_i), .b_i(opnd_i), .op_i(op_i), .fin_i(fin),
    .res_o(as_res), .fout_o(as_f)
  );

  alu8_bitlogic u_bitlogic (
    .a_i(acc_i), .b_i(opnd_i), .sel_i(bit_sel_i), .op_i(op_i), .fin_i(fin),
    .res_o(bl_res), .fout_o(bl_f)
  );

  alu8_rotshift u_rotshift (
    .a_i(acc_i), .b_i(opnd_i), .op_i(op_i), .fin_i(fin),
    .res_o(rs_res), .fout_o(rs_f)
  );

  alu8_decadj u_decadj (
    .a_i(acc_i), .fin_i(fin),
    .res_o(da_res), .fout_o(da_f)
  );

  always_comb begin
    result_o = '0;
    fsel     = fin;
    wr_en_o  = 1'b1;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: begin
        result_o = as_res; fsel = as_f;
      end
      OP_CP: begin
        result_o = as_res; fsel = as_f; wr_en_o = 1'b0;
      end
      OP_AND, OP_OR, OP_XOR, OP_SET, OP_RES: begin
        result_o = bl_res; fsel = bl_f;
      end
      OP_BIT: begin
        result_o = bl_res; fsel = bl_f; wr_en_o = 1'b0;
      end
      OP_RLCA, OP_RRCA, OP_RLA, OP_RRA, OP_RLC, OP_RRC, OP_RL, OP_RR,
      OP_SLA, OP_SRA, OP_SRL: begin
        result_o = rs_res; fsel = rs_f;
      end
      OP_DAA: begin
        result_o = da_res; fsel = da_f;
      end
      default: begin
        result_o = '0; fsel = fin; wr_en_o = 1'b0;
      end
    endcase
    flags_o = {fsel.z, fsel.n, fsel.h, fsel.c, 4'b0000};
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic [7:0] flags_i,
  input logic [4:0] op_i,
  input logic [2:0] bit_sel_i,
  input logic [7:0] result_o,
  input logic [7:0] flags_o,
  input logic       wr_en_o
);
  always_comb begin
    if (!$isunknown({acc_i, opnd_i, flags_i, op_i, bit_sel_i})) begin
      p_low_nibble_clear_r1: assert (flags_o[3:0] == 4'b0000)
        else $error("flag low nibble not zero");
      if (op_i == OP_CP) begin
        p_cmp_no_write_r4: assert (!wr_en_o && flags_o[FN])
          else $error("compare wrote or lost N");
      end
      if (op_i == OP_INC || op_i == OP_DEC) begin
        p_step_keeps_carry_r5: assert (flags_o[FC] == flags_i[FC])
          else $error("inc/dec changed carry");
      end
      if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) begin
        p_logic_zero_r6: assert (flags_o[FZ] == (result_o == 8'h00) && !flags_o[FC])
          else $error("logic flags wrong");
      end
      if (op_i == OP_DAA && flags_i[FN]) begin
        p_daa_sub_keeps_c_r8: assert (flags_o[FC] == flags_i[FC] && !flags_o[FH])
          else $error("daa after subtract flags wrong");
      end
      if (op_i >= OP_RLCA && op_i <= OP_RRA) begin
        p_short_rot_zero_r9: assert (!flags_o[FZ] && !flags_o[FN] && !flags_o[FH])
          else $error("short rotate flags wrong");
      end
      if (op_i >= OP_RLC && op_i <= OP_SRL) begin
        p_gen_rot_zero_r10: assert (flags_o[FZ] == (result_o == 8'h00))
          else $error("general rotate zero wrong");
      end
      if (op_i == OP_BIT) begin
        p_bit_test_r12: assert (flags_o[FH] && !flags_o[FN] && !wr_en_o && result_o == opnd_i)
          else $error("bit test wrong");
      end
      if (op_i == OP_SET || op_i == OP_RES) begin
        p_setres_flags_r13: assert (flags_o[7:4] == flags_i[7:4] && wr_en_o)
          else $error("set/res touched flags");
      end
      if (op_i > OP_RES) begin
        p_undef_idle_r14: assert (!wr_en_o && result_o == 8'h00 && flags_o[7:4] == flags_i[7:4])
          else $error("undefined op acted");
      end
    end
  end
endmodule

bind alu8_core alu8_core_chk u_chk (
  .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i), .op_i(op_i),
  .bit_sel_i(bit_sel_i), .result_o(result_o), .flags_o(flags_o), .wr_en_o(wr_en_o)
);

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] acc, opnd, fl_in;
  logic [4:0] op;
  logic [2:0] sel;
  logic [7:0] res, fl_out;
  logic       we;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  alu8_core dut_i (
    .acc_i(acc), .opnd_i(opnd), .flags_i(fl_in), .op_i(op), .bit_sel_i(sel),
    .result_o(res), .flags_o(fl_out), .wr_en_o(we)
  );

  function automatic string req_of(int o);
    if (o <= 1) return "R2";
    if (o <= 3) return "R3";
    if (o == 4) return "R4";
    if (o <= 6) return "R5";
    if (o <= 9) return "R6";
    if (o == 10) return "R7/R8";
    if (o <= 14) return "R9";
    if (o <= 18) return "R10";
    if (o <= 21) return "R11";
    if (o == 22) return "R12";
    if (o <= 24) return "R13";
    return "R14";
  endfunction

  // Reference: returns {we, flags[7:0], result[7:0]}
  function automatic logic [16:0] ref_model(int o, int a, int b, int f, int s);
    int z, n, h, c, r, w, t, cin, adj;
    z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
    cin = c; r = 0; w = 1;
    case (o)
      0, 1: begin
        t = (o == 1) ? cin : 0;
        r = a + b + t;
        h = ((a % 16) + (b % 16) + t) > 15;
        c = r > 255; r = r % 256; n = 0; z = (r == 0);
      end
      2, 3, 4: begin
        t = (o == 3) ? cin : 0;
        r = a - b - t;
        h = ((a % 16) - (b % 16) - t) < 0;
        c = r < 0; r = (r + 256) % 256; n = 1; z = (r == 0);
        if (o == 4) w = 0;
      end
      5: begin r = (b + 1) % 256; h = (b % 16) == 15; n = 0; z = (r == 0); end
      6: begin r = (b + 255) % 256; h = (b % 16) == 0; n = 1; z = (r == 0); end
      7: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; end
      8: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; end
      9: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; end
      10: begin
        adj = 0;
        if (n == 1) begin
          if (h == 1) adj += 6;
          if (c == 1) adj += 96;
          r = (a - adj + 512) % 256;
        end else begin
          if (h == 1 || (a % 16) > 9) adj += 6;
          if (c == 1 || a > 153) begin adj += 96; c = 1; end else c = 0;
          r = (a + adj) % 256;
        end
        h = 0; z = (r == 0);
      end
      11: begin c = a / 128; r = ((a * 2) % 256) + c; z = 0; n = 0; h = 0; end
      12: begin c = a % 2; r = (a / 2) + c * 128; z = 0; n = 0; h = 0; end
      13: begin c = a / 128; r = ((a * 2) % 256) + cin; z = 0; n = 0; h = 0; end
      14: begin c = a % 2; r = (a / 2) + cin * 128; z = 0; n = 0; h = 0; end
      15: begin c = b / 128; r = ((b * 2) % 256) + c; end
      16: begin c = b % 2; r = (b / 2) + c * 128; end
      17: begin c = b / 128; r = ((b * 2) % 256) + cin; end
      18: begin c = b % 2; r = (b / 2) + cin * 128; end
      19: begin c = b / 128; r = (b * 2) % 256; end
      20: begin c = b % 2; r = (b / 2) + (b / 128) * 128; end
      21: begin c = b % 2; r = b / 2; end
      22: begin r = b; z = ((b >> s) & 1) == 0; n = 0; h = 1; w = 0; end
      23: r = b | (1 << s);
      24: r = b & ~(1 << s) & 255;
      default: begin r = 0; w = 0; end
    endcase
    if (o >= 15 && o <= 21) begin z = (r == 0); n = 0; h = 0; end
    return {w[0], z[0], n[0], h[0], c[0], 4'b0000, r[7:0]};
  endfunction

  task automatic run_vec(int o, int a, int b, int f, int s, string tag);
    logic [16:0] exp_v, got;
    @(negedge clk);
    op = o[4:0]; acc = a[7:0]; opnd = b[7:0]; fl_in = f[7:0]; sel = s[2:0];
    #3;
    exp_v = ref_model(o, a, b, f, s);
    got = {we, fl_out, res};
    checks++;
    if (got !== exp_v) begin
      failures++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h sel=%0d actual we=%0b flags=%02h res=%02h expected we=%0b flags=%02h res=%02h",
               tag, o, a, b, f, s, got[16], got[15:8], got[7:0], exp_v[16], exp_v[15:8], exp_v[7:0]);
    end
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5EED);
    acc = 0; opnd = 0; fl_in = 0; op = 0; sel = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset/idle state: ADD 0+0 (R2)
    run_vec(0, 8'h00, 8'h00, 8'h00, 0, "R2 idle");
    run_vec(1, 8'h0F, 8'h00, 8'h10, 0, "R2 adc nibble carry");
    run_vec(0, 8'hFF, 8'h01, 8'h00, 0, "R2 add wrap");
    run_vec(0, 8'h12, 8'h34, 8'h0F, 0, "R1 low nibble in ignored");
    run_vec(3, 8'h10, 8'h00, 8'h10, 0, "R3 sbc nibble borrow");
    run_vec(2, 8'h00, 8'h01, 8'h00, 0, "R3 sub borrow");
    run_vec(3, 8'h00, 8'hFF, 8'h10, 0, "R3 sbc full borrow");
    run_vec(4, 8'h42, 8'h42, 8'h00, 0, "R4 compare equal");
    run_vec(5, 8'h00, 8'hFF, 8'h10, 0, "R5 inc wrap keeps C");
    run_vec(6, 8'h00, 8'h10, 8'h00, 0, "R5 dec nibble borrow");
    run_vec(7, 8'hF0, 8'h0F, 8'h00, 0, "R6 and zero");
    run_vec(9, 8'hA5, 8'h0F, 8'hF0, 0, "R6 xor");
    run_vec(10, 8'h9A, 8'h00, 8'h00, 0, "R7 daa add");
    run_vec(10, 8'h47, 8'h00, 8'h70, 0, "R8 daa sub");
    run_vec(11, 8'h80, 8'h00, 8'h00, 0, "R9 rlca");
    run_vec(13, 8'h80, 8'h00, 8'h00, 0, "R9 rla zero cleared");
    run_vec(17, 8'h00, 8'h80, 8'h00, 0, "R10 rl zero set");
    run_vec(20, 8'h00, 8'h81, 8'h00, 0, "R11 sra");
    run_vec(19, 8'h00, 8'h80, 8'h00, 0, "R11 sla");
    run_vec(22, 8'h00, 8'h7F, 8'h10, 7, "R12 bit test");
    run_vec(23, 8'h00, 8'h00, 8'hF0, 3, "R13 set");
    run_vec(24, 8'h00, 8'hFF, 8'h50, 0, "R13 res");
    run_vec(31, 8'h33, 8'h44, 8'h5A, 0, "R14 undefined");
    for (int i = 0; i < 4000; i++) begin
      int o, a, b, f, s;
      o = int'($urandom % 32);
      a = int'($urandom % 256);
      b = int'($urandom % 256);
      f = int'($urandom % 256);
      s = int'($urandom % 8);
      run_vec(o, a, b, f, s, req_of(o));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule